// File: doc/BRIEF.md
# Inverse Sinc Pre-Compensation Filter

This block sits in front of a 14-bit DAC and reshapes the sample stream so that the droop of the converter's zero-order hold is cancelled. A zero-order hold rolls off high frequencies along a sin(x)/x curve. The filter boosts those frequencies by roughly the inverse of that curve, so the analog output stays close to flat up to about 45% of the sample clock.

The filter is a three-tap, symmetric FIR with fixed coefficients. Its constant multiplies are built from shifts and adds. The coefficients are expressed in 1/256 units: the centre tap is +218 and each outer tap is -24. These weights lower the gain at DC to 170/256 (about -3.5 dB). That headroom is what lets the high-frequency boost stay inside full scale for most signals. The result is rounded to nearest and clamped to the signed 14-bit range.

A bypass control routes the raw input to the output instead. The bypass path has the same delay as the filter's centre tap, so toggling the mode does not shift timing. While bypass is high, the tap registers hold their contents through a clock enable rather than clocking idle data.

Top module: `isinc_fir`

## Requirements
- R1: While rst_n is low, dout is 0 and all taps are cleared, so that after release a zero input gives a zero output.
- R2: In filter mode, a sample captured on rising edge k reaches dout with weight -24/256 after edge k+1, +218/256 after edge k+2 and -24/256 after edge k+3.
- R3: A constant input X held long enough gives the steady output round(170*X/256).
- R4: Rounding uses the sum S = 218*centre - 24*(newest + oldest). The output is floor((S + 128) / 256), which rounds to nearest with ties toward positive; for example S = -384 gives -1.
- R5: Filter results above 8191 output 8191, and results below -8192 output -8192. A full-scale alternating input of 8191 and -8192 therefore saturates on every output.
- R6: When bypass is high at a rising edge, dout after that edge equals the din sampled two edges earlier, unchanged, including the extreme codes. This matches the centre-tap latency of R2.
- R7: While bypass is high, the three tap registers do not change. On leaving bypass, the first two filtered outputs combine the taps held at entry with the new samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | 1 routes delayed din to dout and freezes the taps |
| din | input | 14 | Signed two's complement input sample |
| dout | output | 14 | Signed two's complement output sample |

## Verification
The bench drives a single impulse to check each coefficient and the output cycle in which it appears. A design with a misplaced tap or a wrong bypass delay shows up as a value in the wrong cycle. An amplitude-16 impulse lands the outer-tap sum exactly on a half step, and a held -1 tests floor behaviour. A design that truncates, or that rounds ties away from zero, gives 0 or -2 where -1 is expected. Full-scale alternation drives the sum past both rails: a design with no clamp, or one that clamps only a single sign, wraps to a value of the opposite sign. A freeze test enters bypass with known taps and feeds new data during bypass. A design whose taps keep shifting during bypass produces the wrong first two outputs after filter mode resumes.

// File: rtl/isinc_pkg.sv
// Package: shared constants for the inverse sinc filter.
// Coefficients are unsigned magnitudes in 1/2**COEF_FRAC units; the outer
// taps are subtracted by the datapath, the centre tap is added.
package isinc_pkg;
    localparam int COEF_W    = 8;
    localparam int COEF_FRAC = 8;
    localparam int NTAPS     = 3;
    localparam logic [COEF_W-1:0] CTR_COEF  = 8'd218;
    localparam logic [COEF_W-1:0] EDGE_COEF = 8'd24;
endpackage

// File: rtl/isinc_taps.sv
// Module: tap delay line with a shared clock enable.
// Assumes: taps[0 +: W] is the newest sample; en low holds every stage.
module isinc_taps #(
    parameter int W = 14,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] taps
);
    logic [W-1:0] stage [N];

    // Shift the line by one sample on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) stage[k] <= '0;
        end else if (en) begin
            stage[0] <= din;
            for (int k = 1; k < N; k++) stage[k] <= stage[k-1];
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_flat
            assign taps[k*W +: W] = stage[k];
        end
    endgenerate
endmodule

// File: rtl/isinc_mac.sv
// Module: constant-coefficient shift-and-add for the symmetric 3-tap FIR.
// Assumes: taps hold signed samples; acc is wide enough for the full sum.
module isinc_mac
    import isinc_pkg::*;
#(
    parameter int W     = 14,
    parameter int ACC_W = 25
) (
    input  logic [NTAPS*W-1:0]      taps,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] ctr_x;
    logic signed [ACC_W-1:0] edge_x;
    logic signed [ACC_W-1:0] ctr_part  [COEF_W];
    logic signed [ACC_W-1:0] edge_part [COEF_W];
    logic signed [ACC_W-1:0] ctr_sum;
    logic signed [ACC_W-1:0] edge_sum;

    // Sign-extend the centre tap and pre-add the symmetric outer pair.
    assign ctr_x  = ACC_W'($signed(taps[W +: W]));
    assign edge_x = ACC_W'($signed(taps[0 +: W])) + ACC_W'($signed(taps[2*W +: W]));

    generate
        for (genvar b = 0; b < COEF_W; b++) begin : g_bit
            assign ctr_part[b]  = CTR_COEF[b]  ? (ctr_x  <<< b) : '0;
            assign edge_part[b] = EDGE_COEF[b] ? (edge_x <<< b) : '0;
        end
    endgenerate

    // Sum the selected shifted copies and form centre minus outer terms.
    always_comb begin
        ctr_sum  = '0;
        edge_sum = '0;
        for (int b = 0; b < COEF_W; b++) begin
            ctr_sum  = ctr_sum + ctr_part[b];
            edge_sum = edge_sum + edge_part[b];
        end
        acc = ctr_sum - edge_sum;
    end
endmodule

// File: rtl/isinc_rsat.sv
// Module: round-to-nearest (ties up) and clamp to a signed W-bit range.
// Assumes: acc carries FRAC fraction bits.
module isinc_rsat #(
    parameter int W     = 14,
    parameter int FRAC  = 8,
    parameter int ACC_W = 25
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [W-1:0]            y
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2**(FRAC-1));
    localparam logic signed [ACC_W-1:0] HI   = ACC_W'(2**(W-1) - 1);
    localparam logic signed [ACC_W-1:0] LO   = -HI - ACC_W'(1);

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    assign biased = acc + HALF;
    assign scaled = biased >>> FRAC;

    // Clamp the rounded value into the output range.
    always_comb begin
        if (scaled > HI)      y = HI[W-1:0];
        else if (scaled < LO) y = LO[W-1:0];
        else                  y = scaled[W-1:0];
    end
endmodule

// File: rtl/isinc_fir.sv
// Module: inverse sinc pre-compensation FIR, top level.
// Filter path: tap line -> shift-add -> round/clamp -> output register.
// Bypass path: two-register delay -> output register (same latency as the
// centre tap). Bypass gates the tap line's clock enable so it holds state.
module isinc_fir
    import isinc_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bypass,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int ACC_W = W + COEF_W + 3;

    logic [NTAPS*W-1:0]      tap_bus;
    logic signed [ACC_W-1:0] acc_w;
    logic [W-1:0]            filt_y;
    logic [W-1:0]            byp_d1;
    logic [W-1:0]            byp_d2;

    isinc_taps #(.W(W), .N(NTAPS)) u_taps (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!bypass),
        .din   (din),
        .taps  (tap_bus)
    );

    isinc_mac #(.W(W), .ACC_W(ACC_W)) u_mac (
        .taps (tap_bus),
        .acc  (acc_w)
    );

    isinc_rsat #(.W(W), .FRAC(COEF_FRAC), .ACC_W(ACC_W)) u_rsat (
        .acc (acc_w),
        .y   (filt_y)
    );

    // Align the raw sample with the filter's centre-tap delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_d1 <= '0;
            byp_d2 <= '0;
        end else begin
            byp_d1 <= din;
            byp_d2 <= byp_d1;
        end
    end

    // Register the selected path as the block output.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= bypass ? byp_d2 : filt_y;
    end
endmodule

// File: rtl/isinc_fir_chk.sv
// Module: property checker for isinc_fir, attached with bind below.
// Assumes: taps and acc are the top's tap bus and pre-rounding sum.
module isinc_fir_chk #(
    parameter int W     = 14,
    parameter int FRAC  = 8,
    parameter int ACC_W = 25
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bypass,
    input logic [W-1:0]            din,
    input logic [W-1:0]            dout,
    input logic [3*W-1:0]          taps,
    input logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W-1:0] TOP_TH = ACC_W'((2**(W-1)) * (2**FRAC) - 2**(FRAC-1));
    localparam logic signed [ACC_W-1:0] BOT_TH = ACC_W'(-(2**(W-1)) * (2**FRAC) - 2**(FRAC-1));
    localparam logic [W-1:0] MAXC = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};

    logic [1:0] warm_cnt;

    // Count edges since reset so history-based checks start only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                 warm_cnt <= '0;
        else if (warm_cnt != 2'd3)  warm_cnt <= warm_cnt + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    a_r5_clip_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && acc >= TOP_TH) |=> (dout == MAXC));

    a_r5_clip_bot: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && acc < BOT_TH) |=> (dout == MINC));

    a_r6_bypass_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && warm_cnt >= 2'd2) |=> (dout == $past(din, 3)));

    a_r7_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> $stable(taps));
endmodule

bind isinc_fir isinc_fir_chk #(.W(W), .FRAC(isinc_pkg::COEF_FRAC), .ACC_W(ACC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bypass (bypass),
    .din    (din),
    .dout   (dout),
    .taps   (tap_bus),
    .acc    (acc_w)
);

// File: tb/tb_isinc_fir.sv
// Bench for isinc_fir: reference model built from the requirements, a
// seeded random run and directed corner cases.
module tb_isinc_fir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass = 1'b0;
    logic [13:0] din = '0;
    wire  [13:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_t0, m_t1, m_t2, m_b0, m_b1, m_out, m_nx;

    isinc_fir dut (.clk(clk), .rst_n(rst_n), .bypass(bypass), .din(din), .dout(dout));

    always #5ns clk = ~clk;

    // Expected filter output from the requirement formulas (R2, R4, R5).
    function automatic int ref_filt(int newest, int centre, int oldest);
        int s;
        int r;
        s = 218 * centre - 24 * (newest + oldest);
        r = (s + 128) >>> 8;
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t0 = 0; m_t1 = 0; m_t2 = 0; m_b0 = 0; m_b1 = 0; m_out = 0;
        end else begin
            m_nx = bypass ? m_b1 : ref_filt(m_t0, m_t1, m_t2);
            m_b1 = m_b0;
            m_b0 = int'($signed(din));
            if (!bypass) begin
                m_t2 = m_t1; m_t1 = m_t0; m_t0 = int'($signed(din));
            end
            m_out = m_nx;
        end
    end

    function automatic int dval();
        return int'($signed(dout));
    endfunction

    task automatic chk(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One cycle: compare against the model, then drive new inputs.
    task automatic cyc(int v, bit b);
        @(negedge clk);
        chk(cur_req, dval(), m_out);
        din = v[13:0];
        bypass = b;
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) cyc(0, 1'b0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        // R1: reset holds output at zero even with input active.
        din = 14'd5000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", dval(), 0);
        end
        rst_n = 1'b1;
        din = '0;
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(0, 1'b0);
        chk("R1", dval(), 0);

        // R2: impulse response, coefficients and their cycles.
        cur_req = "R2";
        cyc(1024, 1'b0); cyc(0, 1'b0);
        cyc(0, 1'b0); chk("R2", dval(), -96);
        cyc(0, 1'b0); chk("R2", dval(), 872);
        cyc(0, 1'b0); chk("R2", dval(), -96);
        flush();

        // R3: DC gain 170/256.
        cur_req = "R3";
        for (int i = 0; i < 5; i++) cyc(4096, 1'b0);
        chk("R3", dval(), 2720);
        for (int i = 0; i < 5; i++) cyc(-3000, 1'b0);
        chk("R3", dval(), -1992);

        // R4: tie rounds upward, negative values floor correctly.
        cur_req = "R4";
        flush();
        cyc(16, 1'b0); cyc(0, 1'b0);
        cyc(0, 1'b0); chk("R4", dval(), -1);
        cyc(0, 1'b0); chk("R4", dval(), 14);
        cyc(0, 1'b0); chk("R4", dval(), -1);
        for (int i = 0; i < 5; i++) cyc(-1, 1'b0);
        chk("R4", dval(), -1);

        // R5: full-scale alternation clamps at both rails.
        cur_req = "R5";
        for (int i = 0; i < 6; i++) cyc((i % 2 == 0) ? 8191 : -8192, 1'b0);
        chk("R5", dval(), 8191);
        cyc(8191, 1'b0); chk("R5", dval(), -8192);
        cyc(-8192, 1'b0); chk("R5", dval(), 8191);

        // R6: bypass passes samples unchanged with centre-tap latency.
        cur_req = "R6";
        cyc(1234, 1'b1); cyc(-8192, 1'b1); cyc(8191, 1'b1);
        cyc(0, 1'b1); chk("R6", dval(), 1234);
        cyc(0, 1'b1); chk("R6", dval(), -8192);
        cyc(0, 1'b1); chk("R6", dval(), 8191);

        // R7: taps hold through bypass and resume from the held values.
        cur_req = "R7";
        flush();
        cyc(1000, 1'b0); cyc(2000, 1'b0); cyc(3000, 1'b0);
        for (int i = 0; i < 5; i++) cyc(111 * (i + 1), 1'b1);
        cyc(0, 1'b0);
        cyc(0, 1'b0); chk("R7", dval(), 1328);
        cyc(0, 1'b0); chk("R7", dval(), 2367);

        // Random stream with occasional mode changes and rail values.
        cur_req = "R2";
        begin
            bit b = 1'b0;
            for (int i = 0; i < 3000; i++) begin
                int v;
                v = int'($urandom_range(0, 16383)) - 8192;
                if ($urandom_range(0, 9) == 0) v = ($urandom_range(0, 1) == 1) ? 8191 : -8192;
                if ($urandom_range(0, 15) == 0) b = ~b;
                cyc(v, b);
            end
        end
        cyc(0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule